// File: doc/BRIEF.md
# Exception Entry and Vector Selector

This block performs trap entry for a small in-order processor core. A pipeline stage that detects a fault presents a one-cycle request carrying the faulting PC, a 6-bit cause code and, where the fault concerns a memory address, the offending virtual address. On the next clock edge the block saves the PC, records the cause and the address, sets exception mode in the status word, and reports for one cycle which of four vectors the fetch unit must jump to: user, kernel, double-fault or debug. The user/kernel/double choice comes from the status word at the moment of the fault. A separate debug request is accepted only when the current interrupt level lies strictly below the configured debug level. An accepted debug request stores the PC and the old status word in shadow registers that belong to that level, and then raises the interrupt level to the debug level.

A misaligned-access request is turned into a general exception with a fixed alignment cause. This happens only when the configuration traps unaligned accesses and does not handle them in hardware. All saved registers can be read and written through a small special-register port, which the handlers use to inspect and restore state.

The sequencing is a state machine that tracks the entry just taken. `ST_IDLE` means no entry is in progress. `ST_USER`, `ST_KERNEL`, `ST_DOUBLE` and `ST_DEBUG` each last one cycle and drive the matching vector code. From any state the transitions are the same: an accepted debug request goes to `ST_DEBUG`. A general request goes to `ST_DOUBLE` if exception mode is already set. Otherwise it goes to `ST_USER` when the user-mode bit is set and to `ST_KERNEL` when it is clear. With no request the machine returns to `ST_IDLE`.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, `vector_valid` is 0, the status word (address 0) reads 0 and every saved register reads 0.
- R2: A general exception taken while the status exception-mode bit (bit 4) is clear writes the PC into the first-level PC register (address 1). One cycle after the request, `vector_valid` is 1 for exactly one cycle. `vector_code` is 0 (user) when the user-mode bit (bit 5) is set and 1 (kernel) when it is clear.
- R3: A general exception taken while exception mode is already set produces `vector_code` 2 (double). With `HAS_DPC`=1 the PC goes to the double-fault PC register (address 2) and address 1 is left unchanged. With `HAS_DPC`=0 the PC goes to address 1.
- R4: Every general exception writes its cause code into the cause register (address 3) and sets exception mode, leaving the user-mode bit and the interrupt-level field (bits 3:0) unchanged.
- R5: The exception-address register (address 4) is loaded with the faulting address only when `exc_vaddr_valid` is 1. Otherwise it keeps its value.
- R6: A debug request is taken only when the status interrupt level is below `DEBUG_LEVEL`. Otherwise it is ignored: no vector is issued and no register changes.
- R7: A taken debug request writes its cause to address 5, the PC to the level register at address 8+`DEBUG_LEVEL`, and the old status word to address 16+`DEBUG_LEVEL`. It then sets the interrupt level to `DEBUG_LEVEL` and sets exception mode, and `vector_code` is 3.
- R8: With `UNALIGN_EXC`=1 and `HW_ALIGN`=0, a misaligned-access request raises a general exception with cause `ALIGN_CAUSE` (default 9), using its PC and with its address loaded into address 4.
- R9: Priority within one cycle is: taken debug request, then general exception, then misaligned access. Losing requests are dropped. A debug request rejected by R6 does not block a general request.
- R10: `sr_rdata` shows the register at `sr_addr` in the same cycle. A write with `sr_we` updates it at the next edge. The status word keeps only bits 5:0. Unmapped addresses read 0. An entry in the same cycle overrides a port write to the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | General exception request pulse |
| exc_cause | input | 6 | Cause code of the general exception |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_vaddr_valid | input | 1 | The request carries a faulting address |
| exc_vaddr | input | 32 | Faulting virtual address |
| mis_valid | input | 1 | Misaligned access request pulse |
| mis_pc | input | 32 | PC of the misaligned access |
| mis_addr | input | 32 | Misaligned address |
| dbg_valid | input | 1 | Debug request pulse |
| dbg_cause | input | 6 | Debug cause code |
| dbg_pc | input | 32 | PC at the debug event |
| sr_we | input | 1 | Special-register write enable |
| sr_addr | input | 5 | Special-register address |
| sr_wdata | input | 32 | Special-register write data |
| sr_rdata | output | 32 | Special-register read data |
| vector_valid | output | 1 | One-cycle vector strobe |
| vector_code | output | 2 | 0 user, 1 kernel, 2 double, 3 debug |

## Verification
A request presented before a rising edge is committed at that edge. Both the vector strobe and the updated register contents are therefore visible in the cycle that follows, and the strobe is low again one cycle later. The bench drives each request on a falling edge and removes it on the next falling edge. At that point it compares `vector_code`, checks that the strobe is still low one cycle after it was raised, and reads the saved registers back through the combinational read port. Ignored requests are checked the same way: the strobe must stay low and the registers they could have changed must read back unchanged in the cycle after the request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_USER,
        ST_KERNEL,
        ST_DOUBLE,
        ST_DEBUG
    } ent_state_t;

    localparam logic [1:0] VEC_USER   = 2'd0;
    localparam logic [1:0] VEC_KERNEL = 2'd1;
    localparam logic [1:0] VEC_DOUBLE = 2'd2;
    localparam logic [1:0] VEC_DEBUG  = 2'd3;

    localparam int SR_AW = 5;
    localparam int XLEN  = 32;
    localparam int CW    = 6;
    localparam int PSW   = 6;

    localparam logic [SR_AW-1:0] SRA_PS       = 5'd0;
    localparam logic [SR_AW-1:0] SRA_EPC1     = 5'd1;
    localparam logic [SR_AW-1:0] SRA_DPC      = 5'd2;
    localparam logic [SR_AW-1:0] SRA_CAUSE    = 5'd3;
    localparam logic [SR_AW-1:0] SRA_VADDR    = 5'd4;
    localparam logic [SR_AW-1:0] SRA_DBGCAUSE = 5'd5;
    localparam int               SRA_LVL_PC   = 8;
    localparam int               SRA_LVL_PS   = 16;

    localparam int PS_EXCM_BIT = 4;
    localparam int PS_UM_BIT   = 5;

endpackage

// File: rtl/exc_req_arb.sv
module exc_req_arb
    import exc_entry_pkg::*;
#(
    parameter int DEBUG_LEVEL = 6,
    parameter int ALIGN_CAUSE = 9,
    parameter bit UNALIGN_EXC = 1'b1,
    parameter bit HW_ALIGN    = 1'b0
) (
    input  logic [3:0]      ps_intlevel,
    input  logic            exc_valid,
    input  logic [CW-1:0]   exc_cause,
    input  logic [XLEN-1:0] exc_pc,
    input  logic            exc_vaddr_valid,
    input  logic [XLEN-1:0] exc_vaddr,
    input  logic            mis_valid,
    input  logic [XLEN-1:0] mis_pc,
    input  logic [XLEN-1:0] mis_addr,
    input  logic            dbg_valid,
    input  logic [CW-1:0]   dbg_cause,
    input  logic [XLEN-1:0] dbg_pc,
    output logic            gen_go,
    output logic            dbg_go,
    output logic [CW-1:0]   sel_cause,
    output logic [XLEN-1:0] sel_pc,
    output logic            sel_vaddr_valid,
    output logic [XLEN-1:0] sel_vaddr
);
    localparam logic [3:0]    DBG_LVL    = 4'(DEBUG_LEVEL);
    localparam logic [CW-1:0] ALIGN_CODE = CW'(ALIGN_CAUSE);
    localparam bit            ALIGN_TRAP = UNALIGN_EXC && !HW_ALIGN;

    logic mis_go;

    always_comb begin
        dbg_go = dbg_valid && (ps_intlevel < DBG_LVL);
        mis_go = mis_valid && ALIGN_TRAP;
        gen_go = !dbg_go && (exc_valid || mis_go);
    end

    always_comb begin
        if (dbg_go) begin
            sel_cause       = dbg_cause;
            sel_pc          = dbg_pc;
            sel_vaddr_valid = 1'b0;
            sel_vaddr       = '0;
        end else if (exc_valid) begin
            sel_cause       = exc_cause;
            sel_pc          = exc_pc;
            sel_vaddr_valid = exc_vaddr_valid;
            sel_vaddr       = exc_vaddr;
        end else begin
            sel_cause       = ALIGN_CODE;
            sel_pc          = mis_pc;
            sel_vaddr_valid = mis_go;
            sel_vaddr       = mis_addr;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gen_go,
    input  logic       dbg_go,
    input  logic       ps_excm,
    input  logic       ps_um,
    output logic       vector_valid,
    output logic [1:0] vector_code
);
    ent_state_t state_q, state_d;

    always_comb begin
        if (dbg_go)
            state_d = ST_DEBUG;
        else if (gen_go && ps_excm)
            state_d = ST_DOUBLE;
        else if (gen_go && ps_um)
            state_d = ST_USER;
        else if (gen_go)
            state_d = ST_KERNEL;
        else
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        vector_valid = 1'b1;
        vector_code  = VEC_KERNEL;
        unique case (state_q)
            ST_IDLE:   vector_valid = 1'b0;
            ST_USER:   vector_code  = VEC_USER;
            ST_KERNEL: vector_code  = VEC_KERNEL;
            ST_DOUBLE: vector_code  = VEC_DOUBLE;
            ST_DEBUG:  vector_code  = VEC_DEBUG;
            default:   vector_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_sr_file.sv
module exc_sr_file
    import exc_entry_pkg::*;
#(
    parameter int DEBUG_LEVEL = 6,
    parameter int NUM_LEVELS  = 6,
    parameter bit HAS_DPC     = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_go,
    input  logic             dbg_go,
    input  logic [CW-1:0]    sel_cause,
    input  logic [XLEN-1:0]  sel_pc,
    input  logic             sel_vaddr_valid,
    input  logic [XLEN-1:0]  sel_vaddr,
    input  logic             sr_we,
    input  logic [SR_AW-1:0] sr_addr,
    input  logic [XLEN-1:0]  sr_wdata,
    output logic [XLEN-1:0]  sr_rdata,
    output logic [PSW-1:0]   ps_q
);
    localparam logic [3:0] DBG_LVL = 4'(DEBUG_LEVEL);

    logic [XLEN-1:0] epc1_q, dpc_q, vaddr_q;
    logic [CW-1:0]   cause_q, dbgcause_q;
    logic [XLEN-1:0] lvl_pc_q [2:NUM_LEVELS];
    logic [PSW-1:0]  lvl_ps_q [2:NUM_LEVELS];

    logic ps_wr;
    assign ps_wr = sr_we && (sr_addr == SRA_PS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (dbg_go) begin
            ps_q[3:0]         <= DBG_LVL;
            ps_q[PS_EXCM_BIT] <= 1'b1;
        end else if (gen_go) begin
            ps_q[PS_EXCM_BIT] <= 1'b1;
        end else if (ps_wr) begin
            ps_q <= sr_wdata[PSW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc1_q     <= '0;
            vaddr_q    <= '0;
            cause_q    <= '0;
            dbgcause_q <= '0;
        end else begin
            if (gen_go && !(ps_q[PS_EXCM_BIT] && HAS_DPC))
                epc1_q <= sel_pc;
            else if (sr_we && sr_addr == SRA_EPC1)
                epc1_q <= sr_wdata;
            if (gen_go && sel_vaddr_valid)
                vaddr_q <= sel_vaddr;
            else if (sr_we && sr_addr == SRA_VADDR)
                vaddr_q <= sr_wdata;
            if (gen_go)
                cause_q <= sel_cause;
            else if (sr_we && sr_addr == SRA_CAUSE)
                cause_q <= sr_wdata[CW-1:0];
            if (dbg_go)
                dbgcause_q <= sel_cause;
            else if (sr_we && sr_addr == SRA_DBGCAUSE)
                dbgcause_q <= sr_wdata[CW-1:0];
        end
    end

    generate
        if (HAS_DPC) begin : g_dpc
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dpc_q <= '0;
                else if (gen_go && ps_q[PS_EXCM_BIT])
                    dpc_q <= sel_pc;
                else if (sr_we && sr_addr == SRA_DPC)
                    dpc_q <= sr_wdata;
            end
        end else begin : g_no_dpc
            assign dpc_q = '0;
        end
    endgenerate

    generate
        for (genvar lv = 2; lv <= NUM_LEVELS; lv++) begin : g_lvl
            localparam logic [SR_AW-1:0] A_PC = SR_AW'(SRA_LVL_PC + lv);
            localparam logic [SR_AW-1:0] A_PS = SR_AW'(SRA_LVL_PS + lv);
            localparam bit IS_DBG = (lv == DEBUG_LEVEL);
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lvl_pc_q[lv] <= '0;
                    lvl_ps_q[lv] <= '0;
                end else begin
                    if (IS_DBG && dbg_go)
                        lvl_pc_q[lv] <= sel_pc;
                    else if (sr_we && sr_addr == A_PC)
                        lvl_pc_q[lv] <= sr_wdata;
                    if (IS_DBG && dbg_go)
                        lvl_ps_q[lv] <= ps_q;
                    else if (sr_we && sr_addr == A_PS)
                        lvl_ps_q[lv] <= sr_wdata[PSW-1:0];
                end
            end
        end
    endgenerate

    always_comb begin
        sr_rdata = '0;
        case (sr_addr)
            SRA_PS:       sr_rdata = XLEN'(ps_q);
            SRA_EPC1:     sr_rdata = epc1_q;
            SRA_DPC:      sr_rdata = dpc_q;
            SRA_CAUSE:    sr_rdata = XLEN'(cause_q);
            SRA_VADDR:    sr_rdata = vaddr_q;
            SRA_DBGCAUSE: sr_rdata = XLEN'(dbgcause_q);
            default:      sr_rdata = '0;
        endcase
        for (int lv = 2; lv <= NUM_LEVELS; lv++) begin
            if (sr_addr == SR_AW'(SRA_LVL_PC + lv)) sr_rdata = lvl_pc_q[lv];
            if (sr_addr == SR_AW'(SRA_LVL_PS + lv)) sr_rdata = XLEN'(lvl_ps_q[lv]);
        end
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int DEBUG_LEVEL = 6,
    parameter int NUM_LEVELS  = 6,
    parameter bit HAS_DPC     = 1'b1,
    parameter int ALIGN_CAUSE = 9,
    parameter bit UNALIGN_EXC = 1'b1,
    parameter bit HW_ALIGN    = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        exc_valid,
    input  logic [5:0]  exc_cause,
    input  logic [31:0] exc_pc,
    input  logic        exc_vaddr_valid,
    input  logic [31:0] exc_vaddr,
    input  logic        mis_valid,
    input  logic [31:0] mis_pc,
    input  logic [31:0] mis_addr,
    input  logic        dbg_valid,
    input  logic [5:0]  dbg_cause,
    input  logic [31:0] dbg_pc,
    input  logic        sr_we,
    input  logic [4:0]  sr_addr,
    input  logic [31:0] sr_wdata,
    output logic [31:0] sr_rdata,
    output logic        vector_valid,
    output logic [1:0]  vector_code
);
    logic            gen_go, dbg_go;
    logic [CW-1:0]   sel_cause;
    logic [XLEN-1:0] sel_pc, sel_vaddr;
    logic            sel_vaddr_valid;
    logic [PSW-1:0]  ps_q;

    exc_req_arb #(
        .DEBUG_LEVEL(DEBUG_LEVEL), .ALIGN_CAUSE(ALIGN_CAUSE),
        .UNALIGN_EXC(UNALIGN_EXC), .HW_ALIGN(HW_ALIGN)
    ) arb_i (
        .ps_intlevel(ps_q[3:0]),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_pc(exc_pc),
        .exc_vaddr_valid(exc_vaddr_valid), .exc_vaddr(exc_vaddr),
        .mis_valid(mis_valid), .mis_pc(mis_pc), .mis_addr(mis_addr),
        .dbg_valid(dbg_valid), .dbg_cause(dbg_cause), .dbg_pc(dbg_pc),
        .gen_go(gen_go), .dbg_go(dbg_go),
        .sel_cause(sel_cause), .sel_pc(sel_pc),
        .sel_vaddr_valid(sel_vaddr_valid), .sel_vaddr(sel_vaddr)
    );

    exc_entry_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .gen_go(gen_go), .dbg_go(dbg_go),
        .ps_excm(ps_q[PS_EXCM_BIT]), .ps_um(ps_q[PS_UM_BIT]),
        .vector_valid(vector_valid), .vector_code(vector_code)
    );

    exc_sr_file #(
        .DEBUG_LEVEL(DEBUG_LEVEL), .NUM_LEVELS(NUM_LEVELS), .HAS_DPC(HAS_DPC)
    ) sr_i (
        .clk(clk), .rst_n(rst_n),
        .gen_go(gen_go), .dbg_go(dbg_go),
        .sel_cause(sel_cause), .sel_pc(sel_pc),
        .sel_vaddr_valid(sel_vaddr_valid), .sel_vaddr(sel_vaddr),
        .sr_we(sr_we), .sr_addr(sr_addr), .sr_wdata(sr_wdata),
        .sr_rdata(sr_rdata), .ps_q(ps_q)
    );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int DEBUG_LEVEL = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       gen_go,
    input logic       dbg_go,
    input logic       dbg_valid,
    input logic [5:0] ps,
    input logic       vector_valid,
    input logic [1:0] vector_code
);
    a_r3_double_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_go && ps[4]) |=> (vector_valid && vector_code == 2'd2));

    a_r2_user_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_go && !ps[4] && ps[5]) |=> (vector_valid && vector_code == 2'd0));

    a_r4_excm_set: assert property (@(posedge clk) disable iff (!rst_n)
        gen_go |=> ps[4]);

    a_r6_debug_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_valid && ps[3:0] >= 4'(DEBUG_LEVEL) && !gen_go) |=> !vector_valid);

    a_r7_debug_level: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_go |=> (ps[3:0] == 4'(DEBUG_LEVEL) && ps[4] && vector_code == 2'd3));

    a_r9_debug_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_go |-> !gen_go);
endmodule

bind exc_entry_unit exc_entry_chk #(.DEBUG_LEVEL(DEBUG_LEVEL)) chk_i (
    .clk(clk), .rst_n(rst_n), .gen_go(gen_go), .dbg_go(dbg_go),
    .dbg_valid(dbg_valid), .ps(ps_q),
    .vector_valid(vector_valid), .vector_code(vector_code)
);

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0, exc_vaddr_valid = 1'b0;
    logic [5:0]  exc_cause = '0, dbg_cause = '0;
    logic [31:0] exc_pc = '0, exc_vaddr = '0, mis_pc = '0, mis_addr = '0, dbg_pc = '0;
    logic        mis_valid = 1'b0, dbg_valid = 1'b0, sr_we = 1'b0;
    logic [4:0]  sr_addr = '0;
    logic [31:0] sr_wdata = '0;
    logic [31:0] sr_rdata;
    logic        vector_valid;
    logic [1:0]  vector_code;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    exc_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_pc(exc_pc),
        .exc_vaddr_valid(exc_vaddr_valid), .exc_vaddr(exc_vaddr),
        .mis_valid(mis_valid), .mis_pc(mis_pc), .mis_addr(mis_addr),
        .dbg_valid(dbg_valid), .dbg_cause(dbg_cause), .dbg_pc(dbg_pc),
        .sr_we(sr_we), .sr_addr(sr_addr), .sr_wdata(sr_wdata),
        .sr_rdata(sr_rdata), .vector_valid(vector_valid), .vector_code(vector_code)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic check_sr(input string req, input logic [4:0] a, input logic [31:0] exp);
        sr_addr = a;
        #1;
        check(req, sr_rdata, exp);
    endtask

    task automatic write_sr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        sr_we = 1'b1; sr_addr = a; sr_wdata = d;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    // Vector is due in the cycle after the committing edge: sampled at the next negedge.
    task automatic check_vec(input string req, input logic [1:0] code);
        check(req, {31'd0, vector_valid}, 32'd1);
        check(req, {30'd0, vector_code}, {30'd0, code});
    endtask

    task automatic check_quiet_next(input string req);
        @(negedge clk);
        check(req, {31'd0, vector_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 vector_valid", {31'd0, vector_valid}, 32'd0);
        check_sr("R1 ps", 5'd0, 32'd0);
        check_sr("R1 epc1", 5'd1, 32'd0);
        check_sr("R1 epc6", 5'd14, 32'd0);
    endtask

    task automatic t_kernel();
        @(negedge clk);
        exc_valid = 1; exc_cause = 6'd5; exc_pc = 32'h1000;
        exc_vaddr_valid = 1; exc_vaddr = 32'hABCD_0000;
        @(negedge clk);
        exc_valid = 0; exc_vaddr_valid = 0;
        check_vec("R2 kernel vector", 2'd1);
        check_sr("R2 epc1", 5'd1, 32'h1000);
        check_sr("R4 cause", 5'd3, 32'd5);
        check_sr("R5 vaddr loaded", 5'd4, 32'hABCD_0000);
        check_sr("R4 ps excm", 5'd0, 32'h10);
        check_quiet_next("R2 one-cycle strobe");
    endtask

    task automatic t_double();
        @(negedge clk);
        exc_valid = 1; exc_cause = 6'd7; exc_pc = 32'h2000;
        exc_vaddr_valid = 0; exc_vaddr = 32'h1111_1111;
        @(negedge clk);
        exc_valid = 0;
        check_vec("R3 double vector", 2'd2);
        check_sr("R3 dpc", 5'd2, 32'h2000);
        check_sr("R3 epc1 kept", 5'd1, 32'h1000);
        check_sr("R5 vaddr kept", 5'd4, 32'hABCD_0000);
        check_sr("R4 cause", 5'd3, 32'd7);
    endtask

    task automatic t_user();
        write_sr(5'd0, 32'hFFFF_FFE0);
        check_sr("R10 ps masked", 5'd0, 32'h20);
        @(negedge clk);
        exc_valid = 1; exc_cause = 6'd2; exc_pc = 32'h3000;
        @(negedge clk);
        exc_valid = 0;
        check_vec("R2 user vector", 2'd0);
        check_sr("R2 epc1 user", 5'd1, 32'h3000);
        check_sr("R4 ps keeps um", 5'd0, 32'h30);
    endtask

    task automatic t_misalign();
        write_sr(5'd0, 32'h0);
        @(negedge clk);
        mis_valid = 1; mis_pc = 32'h4000; mis_addr = 32'h55;
        @(negedge clk);
        mis_valid = 0;
        check_vec("R8 misalign kernel", 2'd1);
        check_sr("R8 cause align", 5'd3, 32'd9);
        check_sr("R8 vaddr", 5'd4, 32'h55);
        check_sr("R8 epc1", 5'd1, 32'h4000);
    endtask

    task automatic t_debug_gated();
        write_sr(5'd0, 32'h6);
        @(negedge clk);
        dbg_valid = 1; dbg_cause = 6'd4; dbg_pc = 32'h9999;
        @(negedge clk);
        dbg_valid = 0;
        check("R6 no vector", {31'd0, vector_valid}, 32'd0);
        check_sr("R6 dbgcause kept", 5'd5, 32'd0);
        check_sr("R6 ps kept", 5'd0, 32'h6);
        check_sr("R6 level pc kept", 5'd14, 32'd0);
    endtask

    task automatic t_debug();
        write_sr(5'd0, 32'h23);
        @(negedge clk);
        dbg_valid = 1; dbg_cause = 6'd1; dbg_pc = 32'h5000;
        @(negedge clk);
        dbg_valid = 0;
        check_vec("R7 debug vector", 2'd3);
        check_sr("R7 dbgcause", 5'd5, 32'd1);
        check_sr("R7 level pc", 5'd14, 32'h5000);
        check_sr("R7 level ps", 5'd22, 32'h23);
        check_sr("R7 ps raised", 5'd0, 32'h36);
    endtask

    task automatic t_priority();
        write_sr(5'd0, 32'h0);
        @(negedge clk);
        dbg_valid = 1; dbg_cause = 6'd2; dbg_pc = 32'h6000;
        exc_valid = 1; exc_cause = 6'd3; exc_pc = 32'h7000;
        mis_valid = 1; mis_addr = 32'h77;
        @(negedge clk);
        check_vec("R9 debug wins", 2'd3);
        check_sr("R9 epc1 kept", 5'd1, 32'h4000);
        check_sr("R9 cause kept", 5'd3, 32'd9);
        check_sr("R9 ps", 5'd0, 32'h16);
        // debug now rejected by level: general must still be taken (double)
        @(negedge clk);
        dbg_valid = 0; exc_valid = 0; mis_valid = 0;
        check_vec("R9 rejected debug falls through", 2'd2);
        check_sr("R9 dpc", 5'd2, 32'h7000);
        check_sr("R9 exc beats misalign", 5'd3, 32'd3);
    endtask

    task automatic t_port_collision();
        @(negedge clk);
        sr_we = 1; sr_addr = 5'd0; sr_wdata = 32'h0;
        exc_valid = 1; exc_cause = 6'd4; exc_pc = 32'h8000;
        @(negedge clk);
        sr_we = 0; exc_valid = 0;
        check_sr("R10 entry beats write", 5'd0, 32'h16);
        check_sr("R10 unmapped", 5'd31, 32'd0);
        write_sr(5'd4, 32'hCAFE_F00D);
        check_sr("R10 vaddr write", 5'd4, 32'hCAFE_F00D);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_kernel();
        t_double();
        t_user();
        t_misalign();
        t_debug_gated();
        t_debug();
        t_priority();
        t_port_collision();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule